// File: doc/BRIEF.md
# Serial ADC Sample Word Assembler

This block sits behind the deserializer of a serial-output ADC receiver and runs on the half-rate processing clock. On every processing cycle each data lane delivers one nibble that is already aligned to bit boundaries. The frame lane delivers one nibble as well. The block joins the nibble stream of each lane into that lane's share of a sample and concatenates the lane shares into a parallel sample word. It raises a one-cycle strobe for each finished word. The default configuration is 12-bit samples over two lanes: each lane carries six bits per sample, so two words complete in every three processing cycles.

A link controller drives the enable input. The block only assembles while enable is high. The first nibble of each lane after the block enters its running state is the most significant bit group of a new sample. A nibble that runs across a sample boundary leaves its remaining bits in a per-lane residue register, and those bits lead the next sample. The frame lane is compared with its expected pattern on every running cycle. A mismatch locks the block in a fault state until enable falls or reset is applied.

There are three control states:
- IDLE is the reset state. It moves to RUN when enable is high.
- RUN returns to IDLE when enable is low. It moves to FAULT when the frame nibble mismatches.
- FAULT returns to IDLE when enable is low.

Top module: `adc_word_assembler`

## Requirements
- R1: While `rst_n` is low, `word_valid_o`, `frame_err_o`, `sample_o` and `frame_cap_o` are all zero.
- R2: Lane 0 uses `data_nib_i[3:0]` and carries the upper LB = SAMPLE_W/LANES sample bits. Lane 1 uses `data_nib_i[7:4]` and carries the lower LB bits. Within a nibble, bit 3 is the earliest bit in time. Each lane sends its share of a sample most significant bit first.
- R3: Each strobed word equals the next sample in sequence. This holds when a nibble holds bits of two samples: the earlier bits close the current sample and the later bits open the next one.
- R4: A strobe is issued for each cycle in which the last bit of a sample arrives. For the default configuration this gives the pattern 0,1,1 repeating from the first running cycle, so exactly two of every three cycles carry a strobe.
- R5: `sample_o` and `word_valid_o` are registered. They appear one clock after the cycle whose nibble completed the sample.
- R6: Within each LB-bit sample slot, the frame lane is 1 in the first ceil(LB/2) bit positions and 0 in the rest. For the default configuration the only legal nibbles are 1110, 0011 and 1000, in that rotation. A legal frame keeps `frame_err_o` low.
- R7: A running cycle with an illegal frame nibble yields no strobe. `frame_err_o` is high from the next clock onward.
- R8: `frame_err_o` stays high while enable stays high. It clears one clock after enable is sampled low, or when reset is applied.
- R9: While enable is low, no strobe is issued and the nibbles are ignored. After enable is sampled high in IDLE, the block runs from the next cycle with an empty residue. The nibble present in the cycle enable was sampled is not used.
- R10: `frame_cap_o` shows the frame nibble sampled on the previous clock, in every state.
- R11: `sample_o` holds its last strobed value whenever `word_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable from the link controller |
| data_nib_i | input | LANES*NIB_W | Aligned data nibbles, one per lane |
| frame_nib_i | input | NIB_W | Aligned frame-lane nibble |
| sample_o | output | SAMPLE_W | Assembled sample word |
| word_valid_o | output | 1 | One-cycle strobe marking a new sample |
| frame_cap_o | output | NIB_W | Frame nibble captured on the previous clock |
| frame_err_o | output | 1 | Sticky frame misalignment flag |

## Verification
The assertions assume that nibbles arrive one per lane per cycle with no gaps while enable is high. They also assume that each lane's bit stream starts on a sample boundary in the first running cycle. The bench keeps to both assumptions. It generates every run from its own table of random samples, starting at bit position zero, and only breaks the frame pattern on purpose, in the cycles it marks as corrupted. Enable is dropped only at the end of a run, and each new run starts from an empty stream. This includes runs that stop partway through a sample.

// File: rtl/adc_asm_pkg.sv
package adc_asm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } asm_state_e;

    // number of leading '1' frame slots inside one lane sample slot
    function automatic int frame_high_slots(input int lane_bits);
        return (lane_bits + 1) / 2;
    endfunction

endpackage

// File: rtl/asm_phase_ctr.sv
// Tracks how many bits of the current sample each lane already holds.
module asm_phase_ctr #(
    parameter int LB    = 6,
    parameter int NIB_W = 4,
    parameter int FW    = $clog2(LB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    output logic [FW-1:0] fill_o,
    output logic          done_o,
    output logic [FW-1:0] over_o
);

    logic [FW-1:0] fill_q;
    logic [FW:0]   sum;
    logic [FW:0]   over_full;

    assign sum       = {1'b0, fill_q} + (FW+1)'(NIB_W);
    assign done_o    = (sum >= (FW+1)'(LB));
    assign over_full = sum - (FW+1)'(LB);
    assign over_o    = over_full[FW-1:0];
    assign fill_o    = fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (clear_i) begin
            fill_q <= '0;
        end else if (step_i) begin
            fill_q <= done_o ? over_full[FW-1:0] : sum[FW-1:0];
        end
    end

endmodule

// File: rtl/asm_lane_packer.sv
// Joins the residue of one lane with its new nibble and splits off a finished lane share.
module asm_lane_packer #(
    parameter int LB    = 6,
    parameter int NIB_W = 4,
    parameter int FW    = $clog2(LB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic             done_i,
    input  logic [FW-1:0]    over_i,
    input  logic [NIB_W-1:0] nib_i,
    output logic [LB-1:0]    word_o
);

    localparam int WW = LB + NIB_W;

    logic [LB-1:0] res_q;
    logic [WW-1:0] wide;
    logic [WW-1:0] shifted;
    logic [WW-1:0] keep_mask;
    logic [WW-1:0] kept;
    logic [LB-1:0] res_d;

    always_comb begin
        wide      = {res_q, nib_i};
        shifted   = wide >> over_i;
        keep_mask = (WW'(1) << over_i) - WW'(1);
        kept      = wide & keep_mask;
        word_o    = shifted[LB-1:0];
        res_d     = done_i ? kept[LB-1:0] : wide[LB-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (clear_i) begin
            res_q <= '0;
        end else if (step_i) begin
            res_q <= res_d;
        end
    end

endmodule

// File: rtl/asm_frame_check.sv
// Compares the frame nibble with the pattern expected at the current fill position.
module asm_frame_check
    import adc_asm_pkg::*;
#(
    parameter int LB    = 6,
    parameter int NIB_W = 4,
    parameter int FW    = $clog2(LB)
) (
    input  logic [FW-1:0]    fill_i,
    input  logic [NIB_W-1:0] frame_i,
    output logic             mismatch_o
);

    localparam int HI = frame_high_slots(LB);

    logic [NIB_W-1:0] expect_nib;

    for (genvar i = 0; i < NIB_W; i++) begin : g_slot
        logic [FW:0] slot_raw;
        logic [FW:0] slot;
        assign slot_raw = {1'b0, fill_i} + (FW+1)'(i);
        assign slot     = (slot_raw >= (FW+1)'(LB)) ? slot_raw - (FW+1)'(LB) : slot_raw;
        assign expect_nib[NIB_W-1-i] = (slot < (FW+1)'(HI));
    end

    assign mismatch_o = (frame_i != expect_nib);

endmodule

// File: rtl/adc_word_assembler.sv
module adc_word_assembler
    import adc_asm_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int LANES    = 2,
    parameter int NIB_W    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_i,
    input  logic [LANES*NIB_W-1:0]   data_nib_i,
    input  logic [NIB_W-1:0]         frame_nib_i,
    output logic [SAMPLE_W-1:0]      sample_o,
    output logic                     word_valid_o,
    output logic [NIB_W-1:0]         frame_cap_o,
    output logic                     frame_err_o
);

    localparam int LB = SAMPLE_W / LANES;
    localparam int FW = $clog2(LB);

    asm_state_e state_q, state_d;

    logic          check_en, bad_frame, step, clear_fill;
    logic [FW-1:0] fill, over;
    logic          done;
    logic          mismatch;
    logic [LB-1:0] lane_word [LANES];
    logic [SAMPLE_W-1:0] asm_word;

    // control qualifiers
    always_comb begin
        check_en   = (state_q == ST_RUN) && en_i;
        bad_frame  = check_en && mismatch;
        step       = check_en && !mismatch;
        clear_fill = (state_q != ST_RUN);
    end

    asm_phase_ctr #(.LB(LB), .NIB_W(NIB_W), .FW(FW)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_fill),
        .step_i  (step),
        .fill_o  (fill),
        .done_o  (done),
        .over_o  (over)
    );

    asm_frame_check #(.LB(LB), .NIB_W(NIB_W), .FW(FW)) u_frame (
        .fill_i     (fill),
        .frame_i    (frame_nib_i),
        .mismatch_o (mismatch)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        asm_lane_packer #(.LB(LB), .NIB_W(NIB_W), .FW(FW)) u_pack (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clear_fill),
            .step_i  (step),
            .done_i  (done),
            .over_i  (over),
            .nib_i   (data_nib_i[g*NIB_W +: NIB_W]),
            .word_o  (lane_word[g])
        );
    end

    // lane 0 supplies the most significant share
    always_comb begin
        asm_word = '0;
        for (int l = 0; l < LANES; l++) begin
            asm_word[SAMPLE_W-1-l*LB -: LB] = lane_word[l];
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = en_i ? ST_RUN : ST_IDLE;
            ST_RUN:   begin
                if (!en_i)          state_d = ST_IDLE;
                else if (bad_frame) state_d = ST_FAULT;
                else                state_d = ST_RUN;
            end
            ST_FAULT: state_d = en_i ? ST_FAULT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_o     <= '0;
            word_valid_o <= 1'b0;
            frame_cap_o  <= '0;
            frame_err_o  <= 1'b0;
        end else begin
            word_valid_o <= step && done;
            if (step && done) sample_o <= asm_word;
            frame_err_o  <= (state_d == ST_FAULT);
            frame_cap_o  <= frame_nib_i;
        end
    end

endmodule

// File: rtl/adc_word_assembler_chk.sv
module adc_word_assembler_chk #(
    parameter int SAMPLE_W = 12,
    parameter int LANES    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en_i,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic                word_valid_o,
    input logic                frame_err_o
);

    localparam int LB = SAMPLE_W / LANES;

    // R9
    no_strobe_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !word_valid_o);

    // R7
    no_strobe_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> !word_valid_o);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err_o && en_i) |=> frame_err_o);

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !frame_err_o);

    // R7
    err_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err_o) |-> $past(en_i));

    // R11
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_o |-> $stable(sample_o));

    if (LB < 8) begin : g_pair
        // R4
        strobe_cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (word_valid_o && $past(word_valid_o)) |=> !word_valid_o);
    end else begin : g_single
        // R4
        strobe_cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
            word_valid_o |=> !word_valid_o);
    end

endmodule

bind adc_word_assembler adc_word_assembler_chk #(
    .SAMPLE_W (SAMPLE_W),
    .LANES    (LANES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .sample_o     (sample_o),
    .word_valid_o (word_valid_o),
    .frame_err_o  (frame_err_o)
);

// File: tb/tb_adc_word_assembler.sv
module tb_adc_word_assembler;

    localparam int SW   = 12;
    localparam int LN   = 2;
    localparam int NW   = 4;
    localparam int LB   = SW / LN;
    localparam int HI   = (LB + 1) / 2;
    localparam int MAXS = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic [LN*NW-1:0] data_nib;
    logic [NW-1:0] frame_nib;
    logic [SW-1:0] sample;
    logic          word_valid;
    logic [NW-1:0] frame_cap;
    logic          frame_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [SW-1:0] smp [MAXS];
    logic [SW-1:0] last_smp;
    logic [NW-1:0] last_frame;

    always #2ns clk = ~clk;

    adc_word_assembler #(.SAMPLE_W(SW), .LANES(LN), .NIB_W(NW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .data_nib_i   (data_nib),
        .frame_nib_i  (frame_nib),
        .sample_o     (sample),
        .word_valid_o (word_valid),
        .frame_cap_o  (frame_cap),
        .frame_err_o  (frame_err)
    );

    // R2: lane l carries sample bits from SW-1-l*LB downward, earliest first
    function automatic logic lane_bit(input int l, input int p);
        int k = p / LB;
        int j = p % LB;
        return smp[k][SW-1-l*LB-j];
    endfunction

    // R6: frame slot is high in the first HI positions of each sample slot
    function automatic logic frame_bit(input int p);
        return (p % LB) < HI;
    endfunction

    function automatic logic sample_done(input int c);
        return ((NW*c + NW) / LB) > ((NW*c) / LB);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_cycle(input int c, input bit corrupt);
        for (int l = 0; l < LN; l++)
            for (int i = 0; i < NW; i++)
                data_nib[l*NW + NW-1-i] = lane_bit(l, NW*c + i);
        for (int i = 0; i < NW; i++)
            frame_nib[NW-1-i] = frame_bit(NW*c + i);
        if (corrupt) frame_nib[0] = ~frame_nib[0];
        last_frame = frame_nib;
    endtask

    task automatic drive_noise();
        data_nib   = (LN*NW)'($urandom);
        frame_nib  = NW'($urandom);
        last_frame = frame_nib;
    endtask

    task automatic do_run(input int ncyc, input int err_at);
        int k;
        bit exp_v;
        for (int s = 0; s < MAXS; s++) smp[s] = SW'($urandom);
        @(negedge clk);
        en = 1'b1;
        drive_noise();
        @(negedge clk);
        check("R9 turn-on cycle strobe", {63'd0, word_valid}, 64'd0);
        drive_cycle(0, err_at == 0);
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (err_at >= 0 && c >= err_at) begin
                check("R7 strobe after frame error", {63'd0, word_valid}, 64'd0);
                check("R8 frame_err sticky", {63'd0, frame_err}, 64'd1);
                check("R11 sample held in fault", {52'd0, sample}, {52'd0, last_smp});
            end else begin
                exp_v = sample_done(c);
                check("R4 R5 strobe cadence", {63'd0, word_valid}, {63'd0, exp_v});
                check("R6 legal frame no error", {63'd0, frame_err}, 64'd0);
                if (exp_v) begin
                    k = (NW*c + NW) / LB - 1;
                    check("R3 R2 sample value", {52'd0, sample}, {52'd0, smp[k]});
                    last_smp = smp[k];
                end else begin
                    check("R11 sample held", {52'd0, sample}, {52'd0, last_smp});
                end
            end
            check("R10 frame capture", {60'd0, frame_cap}, {60'd0, last_frame});
            if (c + 1 < ncyc) drive_cycle(c + 1, err_at == c + 1);
        end
        en = 1'b0;
        drive_noise();
        @(negedge clk);
        check("R9 strobe after enable low", {63'd0, word_valid}, 64'd0);
        check("R8 error cleared by enable low", {63'd0, frame_err}, 64'd0);
        for (int i = 0; i < 3; i++) begin
            drive_noise();
            @(negedge clk);
            check("R9 idle strobe", {63'd0, word_valid}, 64'd0);
            check("R10 idle frame capture", {60'd0, frame_cap}, {60'd0, last_frame});
            check("R11 idle sample held", {52'd0, sample}, {52'd0, last_smp});
        end
    endtask

    initial begin
        #800us;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4217));
        rst_n    = 1'b0;
        en       = 1'b0;
        data_nib = '0;
        last_smp = '0;
        for (int i = 0; i < 3; i++) begin
            drive_noise();
            en = i[0];
            @(negedge clk);
        end
        // R1 reset state
        check("R1 reset strobe", {63'd0, word_valid}, 64'd0);
        check("R1 reset error", {63'd0, frame_err}, 64'd0);
        check("R1 reset sample", {52'd0, sample}, 64'd0);
        check("R1 reset frame capture", {60'd0, frame_cap}, 64'd0);
        en    = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        do_run(12, -1);   // clean run, cadence 0,1,1
        do_run(5, -1);    // stop mid-sample, next run must start clean
        do_run(6, -1);
        do_run(9, 0);     // error on the very first running cycle
        do_run(9, 2);     // error in a cycle that would complete a sample
        do_run(9, 1);
        for (int r = 0; r < 24; r++) begin
            int n = 3 + int'($urandom % 50);
            int e = ($urandom % 3 == 0) ? int'($urandom % n) : -1;
            do_run(n, e);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule